// File: doc/BRIEF.md
# Bounded Random Candidate Generator

This block fills a candidate memory for a population-based optimiser. After a start request it emits a fixed number of candidates, one after another. Each candidate is a vector of a fixed number of features, and the block writes exactly one feature per clock to a memory write port. All values come from one 32-bit shift-register random source. A caller-supplied seed sets the source when a run starts.

The iteration index chooses between two sampling modes. In iteration zero, each feature is drawn uniformly between that feature's lower and upper bound. In later iterations, each feature is drawn around a supplied center vector. The random spread equals the bound width divided by one more than the iteration index, and the result is clamped back into the bounds.

The optimiser's controller pulses `start`, waits for `done`, and then runs fitness evaluation on the filled memory. Bounds, center and iteration index are flat buses. They must stay steady while `busy` is high.

Top module: `cand_gen`

## Requirements
- R1: While reset is held, and after reset with no start, `busy`, `wr_en` and `done` are low.
- R2: The random state is 32 bits wide. When a start is accepted, the state loads `seed`, or 32'hB5A317C9 if `seed` is zero. One step shifts the state right by one bit and, if the bit shifted out was 1, XORs the result with 32'h80200003. Write number j of a run (counting from 0) uses the state after j steps.
- R3: With `iter` equal to 0, let u be state bits [31:32-W], read as unsigned. The value is lo + floor(u·(hi−lo+1)/2^W).
- R4: With `iter` = k > 0, let r be state bits [31:31-W], read as a signed number. The offset is floor(r·(hi−lo)/2^W), divided by k+1 with truncation toward zero. The value is ctr + offset, clamped to the range [lo, hi].
- R5: Every written value lies in [lo, hi] of its feature, provided lo ≤ hi.
- R6: Feature f takes its lo, hi and ctr from bits [f·W +: W] of the matching bus. Writes come one per clock with no gaps. The write address is candidate·L + feature, running from 0 up to N·L−1, with the feature index changing fastest.
- R7: `done` is high for exactly one cycle, in the same cycle as the write to address N·L−1. `busy` is already low in that cycle.
- R8: A start raised while `busy` is high is ignored, and the run continues unchanged. A start raised in the `done` cycle is accepted.
- R9: A start is sampled at a clock edge. `busy` rises at that edge, and the first write appears after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled while idle |
| seed | input | 32 | Seed for the random state (zero is replaced) |
| iter | input | ITER_W | Iteration index; 0 selects uniform sampling |
| lo_bus | input | L_FEAT·W | Per-feature lower bounds |
| hi_bus | input | L_FEAT·W | Per-feature upper bounds |
| ctr_bus | input | L_FEAT·W | Per-feature center-of-mass values |
| busy | output | 1 | A run is in progress |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | W | Memory write data |
| done | output | 1 | One-cycle pulse with the final write |

## Verification
Three events can share one clock cycle: the final write, the `done` pulse, and a new start request. The bench provokes this by raising `start`, with a fresh seed and iteration index, in the very cycle where it sees `done`. It then checks that `busy` rises at the next edge. It also checks that the new run's address-0 write comes one cycle later and carries the value predicted from the new seed, while the finished run's final write still matches its own prediction. A start raised in the middle of a run is checked as well: the data sequence must continue unchanged.

// File: rtl/cand_gen_pkg.sv
package cand_gen_pkg;

   localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
   localparam logic [31:0] SEED_SUB  = 32'hB5A3_17C9;

   function automatic logic [31:0] lfsr_step(input logic [31:0] s);
      logic [31:0] n;
      n = {1'b0, s[31:1]};
      if (s[0]) n = n ^ LFSR_TAPS;
      return n;
   endfunction

endpackage

// File: rtl/cand_gen_lfsr.sv
module cand_gen_lfsr
   import cand_gen_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] seed,
   input  logic        adv,
   output logic [31:0] state
);

   logic [31:0] seed_eff;

   assign seed_eff = (seed == 32'd0) ? SEED_SUB : seed;

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= SEED_SUB;
      else if (load) state <= seed_eff;
      else if (adv)  state <= lfsr_step(state);
   end

endmodule

// File: rtl/cand_gen_seq.sv
module cand_gen_seq #(
   parameter int N_CAND = 4,
   parameter int L_FEAT = 3,
   localparam int NL     = N_CAND * L_FEAT,
   localparam int ADDR_W = (NL > 1) ? $clog2(NL) : 1,
   localparam int FEAT_W = (L_FEAT > 1) ? $clog2(L_FEAT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              run,
   output logic              last,
   output logic [FEAT_W-1:0] feat,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NL - 1);
   localparam logic [FEAT_W-1:0] LAST_FEAT = FEAT_W'(L_FEAT - 1);

   assign last = run && (addr == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         feat <= '0;
         addr <= '0;
      end else if (!run) begin
         if (start) begin
            run  <= 1'b1;
            feat <= '0;
            addr <= '0;
         end
      end else begin
         if (last) run <= 1'b0;
         addr <= addr + ADDR_W'(1);
         feat <= (feat == LAST_FEAT) ? '0 : feat + FEAT_W'(1);
      end
   end

endmodule

// File: rtl/cand_gen_map.sv
module cand_gen_map #(
   parameter int W      = 12,
   parameter int ITER_W = 4
) (
   input  logic [W:0]        rbits,
   input  logic [W-1:0]      lo,
   input  logic [W-1:0]      hi,
   input  logic [W-1:0]      ctr,
   input  logic [ITER_W-1:0] iter,
   output logic [W-1:0]      value
);

   localparam int PW = 2 * W + 4;

   logic [W-1:0]   u;
   logic [W:0]     span;
   logic [2*W:0]   uprod;
   logic [W-1:0]   uni_v;

   logic signed [PW-1:0] rs_x, dif_x, prod, scaled, dvs, off, sum, lo_x, hi_x;
   logic [W-1:0]         ctr_v;

   // uniform mode
   always_comb begin
      u     = rbits[W:1];
      span  = {1'b0, hi} - {1'b0, lo} + (W+1)'(1);
      uprod = {{(W+1){1'b0}}, u} * {{W{1'b0}}, span};
      uni_v = lo + W'(uprod >> W);
   end

   // contraction mode
   always_comb begin
      rs_x   = PW'($signed(rbits));
      lo_x   = PW'(lo);
      hi_x   = PW'(hi);
      dif_x  = hi_x - lo_x;
      prod   = rs_x * dif_x;
      scaled = prod >>> W;
      dvs    = PW'(iter) + PW'(1);
      off    = scaled / dvs;
      sum    = PW'(ctr) + off;
      if (sum < lo_x)      ctr_v = lo;
      else if (sum > hi_x) ctr_v = hi;
      else                 ctr_v = W'(sum);
   end

   assign value = (iter == '0) ? uni_v : ctr_v;

endmodule

// File: rtl/cand_gen.sv
module cand_gen #(
   parameter int N_CAND = 4,
   parameter int L_FEAT = 3,
   parameter int W      = 12,
   parameter int ITER_W = 4,
   localparam int NL     = N_CAND * L_FEAT,
   localparam int ADDR_W = (NL > 1) ? $clog2(NL) : 1,
   localparam int FEAT_W = (L_FEAT > 1) ? $clog2(L_FEAT) : 1,
   localparam int SLOTS  = 1 << FEAT_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [31:0]           seed,
   input  logic [ITER_W-1:0]     iter,
   input  logic [L_FEAT*W-1:0]   lo_bus,
   input  logic [L_FEAT*W-1:0]   hi_bus,
   input  logic [L_FEAT*W-1:0]   ctr_bus,
   output logic                  busy,
   output logic                  wr_en,
   output logic [ADDR_W-1:0]     wr_addr,
   output logic [W-1:0]          wr_data,
   output logic                  done
);

   generate
      if (W < 2 || W > 24) begin : g_bad_w
         $error("cand_gen: W must lie in 2..24");
      end
      if (N_CAND < 1 || L_FEAT < 1) begin : g_bad_dim
         $error("cand_gen: N_CAND and L_FEAT must be at least 1");
      end
      if (ITER_W < 1 || ITER_W > W) begin : g_bad_iter
         $error("cand_gen: ITER_W must lie in 1..W");
      end
   endgenerate

   logic              run, last;
   logic [FEAT_W-1:0] feat;
   logic [ADDR_W-1:0] addr;
   logic [31:0]       state;
   logic [W-1:0]      value;

   logic [W-1:0] lo_arr  [SLOTS];
   logic [W-1:0] hi_arr  [SLOTS];
   logic [W-1:0] ctr_arr [SLOTS];

   generate
      for (genvar f = 0; f < SLOTS; f++) begin : g_slot
         if (f < L_FEAT) begin : g_used
            assign lo_arr[f]  = lo_bus[f*W +: W];
            assign hi_arr[f]  = hi_bus[f*W +: W];
            assign ctr_arr[f] = ctr_bus[f*W +: W];
         end else begin : g_pad
            assign lo_arr[f]  = '0;
            assign hi_arr[f]  = '0;
            assign ctr_arr[f] = '0;
         end
      end
   endgenerate

   cand_gen_seq #(.N_CAND(N_CAND), .L_FEAT(L_FEAT)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .run   (run),
      .last  (last),
      .feat  (feat),
      .addr  (addr)
   );

   cand_gen_lfsr u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start && !run),
      .seed  (seed),
      .adv   (run),
      .state (state)
   );

   cand_gen_map #(.W(W), .ITER_W(ITER_W)) u_map (
      .rbits (state[31 -: W+1]),
      .lo    (lo_arr[feat]),
      .hi    (hi_arr[feat]),
      .ctr   (ctr_arr[feat]),
      .iter  (iter),
      .value (value)
   );

   assign busy = run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         done    <= 1'b0;
      end else begin
         wr_en   <= run;
         wr_addr <= addr;
         wr_data <= value;
         done    <= last;
      end
   end

endmodule

// File: rtl/cand_gen_chk.sv
module cand_gen_chk #(
   parameter int N_CAND = 4,
   parameter int L_FEAT = 3,
   parameter int W      = 12,
   localparam int NL     = N_CAND * L_FEAT,
   localparam int ADDR_W = (NL > 1) ? $clog2(NL) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [W-1:0]        wr_data,
   input logic                done,
   input logic [L_FEAT*W-1:0] lo_bus,
   input logic [L_FEAT*W-1:0] hi_bus
);

   logic [W-1:0] lo_w, hi_w;
   int           fsel;

   assign fsel = int'(wr_addr) % L_FEAT;
   assign lo_w = W'(lo_bus >> (W * fsel));
   assign hi_w = W'(hi_bus >> (W * fsel));

   // R5
   in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_data >= lo_w && wr_data <= hi_w));

   // R6
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !$past(wr_en)) |-> (wr_addr == '0));

   // R6
   step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

   // R7
   done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_en && wr_addr == ADDR_W'(NL - 1) && !busy));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   run_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> wr_en);

   // R9
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && !wr_en));

endmodule

bind cand_gen cand_gen_chk #(.N_CAND(N_CAND), .L_FEAT(L_FEAT), .W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .done    (done),
   .lo_bus  (lo_bus),
   .hi_bus  (hi_bus)
);

// File: tb/cand_gen_bench.sv
`timescale 1ns/1ps
module cand_gen_bench;

   localparam int N  = 4;
   localparam int L  = 3;
   localparam int W  = 12;
   localparam int IW = 4;
   localparam int NL = N * L;
   localparam int AW = $clog2(NL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] seed = '0;
   logic [IW-1:0] iter = '0;
   logic [L*W-1:0] lo_bus, hi_bus, ctr_bus;
   logic busy, wr_en, done;
   logic [AW-1:0] wr_addr;
   logic [W-1:0] wr_data;

   int lo_a [L];
   int hi_a [L];
   int ce_a [L];
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   always_comb begin
      for (int f = 0; f < L; f++) begin
         lo_bus[f*W +: W]  = W'(lo_a[f]);
         hi_bus[f*W +: W]  = W'(hi_a[f]);
         ctr_bus[f*W +: W] = W'(ce_a[f]);
      end
   end

   cand_gen #(.N_CAND(N), .L_FEAT(L), .W(W), .ITER_W(IW)) u_cand_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .iter(iter),
      .lo_bus(lo_bus), .hi_bus(hi_bus), .ctr_bus(ctr_bus),
      .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R2 model
   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] n;
      n = s >> 1;
      if (s[0]) n = n ^ 32'h8020_0003;
      return n;
   endfunction

   // R3 / R4 model
   function automatic longint expv(input logic [31:0] st, input int f, input int it);
      longint lo, hi, ce, u, r, sc, off, v;
      lo = lo_a[f]; hi = hi_a[f]; ce = ce_a[f];
      if (it == 0) begin
         u = longint'(st >> (32 - W));
         return lo + ((u * (hi - lo + 1)) >> W);
      end
      r = longint'(st >> (31 - W));
      if (r >= (longint'(1) << W)) r = r - (longint'(1) << (W + 1));
      sc = (r * (hi - lo)) >>> W;
      off = sc / (it + 1);
      v = ce + off;
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      return v;
   endfunction

   task automatic collect(input logic [31:0] sd, input int it, input bit poke,
                          input bit chain, input logic [31:0] nsd, input int nit);
      logic [31:0] st;
      int cnt;
      bit fin;
      string tg;
      longint e;
      st = (sd == 32'd0) ? 32'hB5A3_17C9 : sd;
      cnt = 0;
      fin = 0;
      tg = (it == 0) ? "R3 uniform" : "R4 contraction";
      for (int cyc = 0; cyc < NL + 4 && !fin; cyc++) begin
         @(negedge clk);
         if (wr_en) begin
            e = expv(st, cnt % L, it);
            chk(wr_addr == AW'(cnt), "R6 address", wr_addr, cnt);
            chk(wr_data == W'(e), tg, wr_data, e);
            chk(wr_data >= W'(lo_a[cnt % L]) && wr_data <= W'(hi_a[cnt % L]), "R5 in bounds",
                wr_data, lo_a[cnt % L]);
            st = nxt(st);
            if (done) begin
               chk(cnt == NL - 1, "R7 done at last write", cnt, NL - 1);
               chk(busy == 1'b0, "R7 busy low with done", busy, 0);
               fin = 1;
            end
            cnt++;
         end else if (cnt > 0) begin
            chk(1'b0, "R6 gap in writes", 0, 1);
         end
         if (poke && cyc == 2) begin
            start = 1'b1;
            seed  = 32'hDEAD_BEEF;
         end else begin
            start = 1'b0;
         end
         if (chain && fin) begin
            start = 1'b1;
            seed  = nsd;
            iter  = IW'(nit);
         end
      end
      chk(fin, "R7 done seen", fin, 1);
      chk(cnt == NL, "R6 write count", cnt, NL);
   endtask

   task automatic do_run(input logic [31:0] sd, input int it, input bit poke);
      @(negedge clk);
      start = 1'b1; seed = sd; iter = IW'(it);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      chk(wr_en == 1'b0, "R9 no write yet", wr_en, 0);
      collect(sd, it, poke, 1'b0, 32'd0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      lo_a = '{100, 0, 777};
      hi_a = '{3000, 4095, 777};
      ce_a = '{1500, 2048, 777};
      repeat (3) @(negedge clk);
      chk(busy == 0 && wr_en == 0 && done == 0, "R1 in reset", {busy, wr_en, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 0 && wr_en == 0 && done == 0, "R1 idle", {busy, wr_en, done}, 0);

      // R3, R4 sweep of every iteration index
      for (int k = 0; k < (1 << IW); k++) do_run(32'h1234_5678, k, 1'b0);
      // R2 zero seed substitution
      do_run(32'd0, 0, 1'b0);
      do_run(32'd0, 3, 1'b0);
      // seeds sweep
      for (int s = 1; s < 6; s++) begin
         do_run(32'h9E37_79B9 * s, 0, 1'b0);
         do_run(32'h9E37_79B9 * s, s, 1'b0);
      end
      // R4 clamp at the upper and lower bounds
      ce_a = '{3000, 4095, 777};
      do_run(32'hCAFE_0001, 1, 1'b0);
      do_run(32'h0BAD_F00D, 1, 1'b0);
      ce_a = '{100, 0, 777};
      do_run(32'hCAFE_0001, 1, 1'b0);
      do_run(32'h0BAD_F00D, 2, 1'b0);
      ce_a = '{1500, 2048, 777};
      // R8 start while busy is ignored
      do_run(32'h5555_AAAA, 0, 1'b1);
      do_run(32'h5555_AAAA, 5, 1'b1);
      // R8 start in the done cycle is accepted
      @(negedge clk);
      start = 1'b1; seed = 32'h0F0F_1234; iter = '0;
      @(negedge clk);
      start = 1'b0;
      collect(32'h0F0F_1234, 0, 1'b0, 1'b1, 32'h7777_0001, 4);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 start in done cycle taken", busy, 1);
      chk(wr_en == 1'b0, "R8 no write in load cycle", wr_en, 0);
      collect(32'h7777_0001, 4, 1'b0, 1'b0, 32'd0, 0);
      repeat (2) @(negedge clk);
      chk(busy == 0 && done == 0, "R7 idle after run", {busy, done}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule